// File: doc/BRIEF.md
# Single-wire command acknowledge pulse generator

This block runs on the target side of a single-wire, open-drain debug link. The host issues a command, and some time later the target's bus side executes it. The block then tells the host that the command is done. It does this by pulling the shared pin low for a fixed number of serial clock periods. It then drives the pin actively high for one period to sharpen the rising edge, and releases the pin. The serial clock is one eighth of the system clock. Inside the block it exists only as a free-running clock enable.

The receive logic raises `cmd_end` on the serial tick that closes the last command bit, and passes a command-kind tag with it. The bus side raises `exec_done` once the command has executed. The block does not start the pulse until a guaranteed quiet gap has passed since the command ended. It sets no limit on how long it waits for the execution strobe. If the core drops into a low-power state first, the pending command is discarded without an acknowledge. When the pin is released, a one-cycle completion strobe tells the transmit logic that it may start. A companion flag marks the case where the acknowledged command was a read.

Top module: `ack_pulse_gen`

## Requirements
- R1: After reset, `pin_oe`, `ack_done`, `ack_rd` and `overrun` are all 0.
- R2: The low phase drives `pin_oe`=1 and `pin_out`=0 for exactly 16 serial periods. A serial period is 8 system clocks, taken from a free-running divider, so the low phase lasts 128 clocks.
- R3: The cycle after the low phase ends, the block drives `pin_oe`=1 and `pin_out`=1 for exactly one serial period (8 clocks), then sets `pin_oe` to 0.
- R4: The low phase begins no earlier than 257 clocks after the cycle in which `cmd_end` was sampled. The first, partial serial period is not counted, so the block waits 32 full periods. If `exec_done` came early, the low phase begins no later than 265 clocks after that cycle.
- R5: There is no upper bound on the wait for `exec_done`. Once the gap is met, the low phase begins 1 to 8 clocks after the cycle that carries `exec_done`.
- R6: An `exec_done` strobe that arrives before the gap is met is held, and the pulse starts on the first serial tick at which the gap is satisfied.
- R7: `lowpwr_enter` while a command is pending and the pulse has not begun cancels the command. The pin is never driven for that command and `ack_done` never rises. `lowpwr_enter` during the pulse has no effect.
- R8: `ack_done` is high for exactly one clock, in the first cycle after the pin is released. `ack_rd` is high in that same cycle only if the captured `cmd_kind` was 2'b01 (read). Kinds 2'b00 (write) and 2'b10/2'b11 (control) are also acknowledged, with `ack_rd`=0.
- R9: A `cmd_end` while a command is pending or being acknowledged is ignored. The timing and the kind of the first command are unchanged. The ignored strobe sets the sticky `overrun` flag, which stays set until reset.
- R10: While `ack_en`=0, `pin_oe` is 0 in the same cycle and any pulse in progress is abandoned. `cmd_end` and `exec_done` are ignored and `overrun` is not set. Re-enabling does not resume an abandoned pulse.
- R11: An `exec_done` strobe with no command pending is ignored and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ack_en | input | 1 | Enables the acknowledge mechanism |
| cmd_end | input | 1 | One-cycle strobe at the end of a received command |
| cmd_kind | input | 2 | Command kind, sampled with `cmd_end`: 00 write, 01 read, 10/11 control |
| exec_done | input | 1 | One-cycle strobe from the bus side when the command has executed |
| lowpwr_enter | input | 1 | Core is entering a wait or stop state |
| pin_oe | output | 1 | Pin driver enable; 0 means high impedance |
| pin_out | output | 1 | Value driven on the pin while `pin_oe` is 1 |
| ack_done | output | 1 | One-cycle strobe when the pin is released after the pulse |
| ack_rd | output | 1 | High with `ack_done` when the acknowledged command was a read |
| overrun | output | 1 | Sticky flag: a command ended while another was still in flight |

## Verification
The hardest cases to reach from the ports are the phase of the hidden divide-by-8 enable relative to `cmd_end`, and the point where a late `exec_done` lands inside a serial period. The bench never reads the divider. It drives `cmd_end` and `exec_done` at random cycle offsets and checks the pulse start against bounds wide enough to cover every divider phase. Some directed cases are timed from pin activity that the bench itself sees. These inject `lowpwr_enter`, a second `cmd_end` and a drop of `ack_en` exactly in the pending window or in the middle of the low phase.

// File: rtl/ack_pkg.sv
package ack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_LOW   = 2'd2,
    ST_SPEED = 2'd3
  } ack_state_e;

  localparam logic [1:0] KIND_READ = 2'b01;
endpackage

// File: rtl/ack_tick_div.sv
module ack_tick_div #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_n;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_n = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/ack_gap_timer.sv
module ack_gap_timer #(
  parameter int MIN_GAP = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  input  logic tick,
  output logic gap_met
);
  localparam int GW = $clog2(MIN_GAP + 1);

  logic [GW-1:0] cnt_q, cnt_n;

  assign gap_met = (cnt_q == GW'(MIN_GAP));

  always_comb begin
    cnt_n = cnt_q;
    if (clear)
      cnt_n = '0;
    else if (count_en && tick && !gap_met)
      cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/ack_seq.sv
module ack_seq
  import ack_pkg::*;
#(
  parameter int LOW_TICKS = 16,
  parameter int SPD_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ack_en,
  input  logic       cmd_end,
  input  logic [1:0] cmd_kind,
  input  logic       exec_done,
  input  logic       lowpwr,
  input  logic       gap_met,
  output logic       gap_clr,
  output logic       gap_cnt_en,
  output ack_state_e state,
  output logic       drv_oe,
  output logic       drv_val,
  output logic       ack_done,
  output logic       ack_rd,
  output logic       overrun
);
  localparam int PH_MAX = (LOW_TICKS > SPD_TICKS) ? LOW_TICKS : SPD_TICKS;
  localparam int PW     = $clog2(PH_MAX + 1);

  ack_state_e st_q, st_n;
  logic [PW-1:0] ph_q, ph_n;
  logic          done_q, done_n;
  logic [1:0]    kind_q, kind_n;
  logic          ovr_q, ovr_n;
  logic          fin;
  logic          ack_done_q, ack_rd_q;

  always_comb begin
    st_n    = st_q;
    ph_n    = ph_q;
    done_n  = done_q;
    kind_n  = kind_q;
    ovr_n   = ovr_q;
    fin     = 1'b0;
    gap_clr = 1'b0;
    if (!ack_en) begin
      st_n   = ST_IDLE;
      done_n = 1'b0;
      ph_n   = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_end) begin
            st_n    = ST_PEND;
            gap_clr = 1'b1;
            done_n  = 1'b0;
            kind_n  = cmd_kind;
          end
        end
        ST_PEND: begin
          if (cmd_end) ovr_n = 1'b1;
          if (lowpwr) begin
            st_n   = ST_IDLE;
            done_n = 1'b0;
          end else begin
            if (exec_done) done_n = 1'b1;
            if (tick && gap_met && (done_q || exec_done)) begin
              st_n   = ST_LOW;
              ph_n   = '0;
              done_n = 1'b0;
            end
          end
        end
        ST_LOW: begin
          if (cmd_end) ovr_n = 1'b1;
          if (tick) begin
            if (ph_q == PW'(LOW_TICKS - 1)) begin
              st_n = ST_SPEED;
              ph_n = '0;
            end else begin
              ph_n = ph_q + 1'b1;
            end
          end
        end
        ST_SPEED: begin
          if (cmd_end) ovr_n = 1'b1;
          if (tick) begin
            if (ph_q == PW'(SPD_TICKS - 1)) begin
              st_n = ST_IDLE;
              ph_n = '0;
              fin  = 1'b1;
            end else begin
              ph_n = ph_q + 1'b1;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ph_q       <= '0;
      done_q     <= 1'b0;
      kind_q     <= '0;
      ovr_q      <= 1'b0;
      ack_done_q <= 1'b0;
      ack_rd_q   <= 1'b0;
    end else begin
      st_q       <= st_n;
      ph_q       <= ph_n;
      done_q     <= done_n;
      kind_q     <= kind_n;
      ovr_q      <= ovr_n;
      ack_done_q <= fin;
      ack_rd_q   <= fin && (kind_q == KIND_READ);
    end
  end

  assign state      = st_q;
  assign gap_cnt_en = (st_q == ST_PEND);
  assign drv_oe     = (st_q == ST_LOW) || (st_q == ST_SPEED);
  assign drv_val    = (st_q == ST_SPEED);
  assign ack_done   = ack_done_q;
  assign ack_rd     = ack_rd_q;
  assign overrun    = ovr_q;
endmodule

// File: rtl/ack_pulse_gen.sv
module ack_pulse_gen
  import ack_pkg::*;
#(
  parameter int DIV       = 8,
  parameter int LOW_TICKS = 16,
  parameter int SPD_TICKS = 1,
  parameter int MIN_GAP   = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_en,
  input  logic       cmd_end,
  input  logic [1:0] cmd_kind,
  input  logic       exec_done,
  input  logic       lowpwr_enter,
  output logic       pin_oe,
  output logic       pin_out,
  output logic       ack_done,
  output logic       ack_rd,
  output logic       overrun
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick;
  logic       gap_met, gap_clr, gap_cnt_en;
  logic       drv_oe, drv_val;
  ack_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ack_tick_div #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick)
  );

  ack_gap_timer #(.MIN_GAP(MIN_GAP)) u_gap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear    (gap_clr),
    .count_en (gap_cnt_en),
    .tick     (tick),
    .gap_met  (gap_met)
  );

  ack_seq #(.LOW_TICKS(LOW_TICKS), .SPD_TICKS(SPD_TICKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (tick),
    .ack_en     (ack_en),
    .cmd_end    (cmd_end),
    .cmd_kind   (cmd_kind),
    .exec_done  (exec_done),
    .lowpwr     (lowpwr_enter),
    .gap_met    (gap_met),
    .gap_clr    (gap_clr),
    .gap_cnt_en (gap_cnt_en),
    .state      (state),
    .drv_oe     (drv_oe),
    .drv_val    (drv_val),
    .ack_done   (ack_done),
    .ack_rd     (ack_rd),
    .overrun    (overrun)
  );

  assign pin_oe  = drv_oe & ack_en;
  assign pin_out = drv_val;
endmodule

// File: rtl/ack_pulse_gen_chk.sv
module ack_pulse_gen_chk
  import ack_pkg::*;
#(
  parameter int DIV       = 8,
  parameter int LOW_TICKS = 16,
  parameter int MIN_GAP   = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_en,
  input logic       cmd_end,
  input logic       lowpwr,
  input logic       pin_oe,
  input logic       pin_out,
  input logic       ack_done,
  input logic       overrun,
  input ack_state_e state
);
  logic        low_drv;
  logic [15:0] low_run_q;
  logic [15:0] since_q;
  logic        accept;

  assign low_drv = pin_oe && !pin_out;
  assign accept  = cmd_end && ack_en && (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
      since_q   <= '0;
    end else begin
      low_run_q <= low_drv ? low_run_q + 1'b1 : '0;
      if (accept)                since_q <= '0;
      else if (since_q != 16'hFFFF) since_q <= since_q + 1'b1;
    end
  end

  // R2
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(low_drv) && !low_drv && ack_en && $past(ack_en))
      |-> (low_run_q == 16'(LOW_TICKS * DIV)));

  // R3
  speedup_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(low_drv) && ack_en && $past(ack_en)) |-> (pin_oe && pin_out));

  // R4
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_drv) |-> (since_q >= 16'(MIN_GAP * DIV)));

  // R7
  lowpwr_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PEND && lowpwr && ack_en) |=> !pin_oe);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done |=> !ack_done);

  // R8
  done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done |-> (!pin_oe && $past(pin_oe && pin_out)));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind ack_pulse_gen ack_pulse_gen_chk #(
  .DIV(DIV), .LOW_TICKS(LOW_TICKS), .MIN_GAP(MIN_GAP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack_en   (ack_en),
  .cmd_end  (cmd_end),
  .lowpwr   (lowpwr_enter),
  .pin_oe   (pin_oe),
  .pin_out  (pin_out),
  .ack_done (ack_done),
  .overrun  (overrun),
  .state    (state)
);

// File: tb/ack_pulse_gen_tb.sv
`timescale 1ns/1ps
module ack_pulse_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ack_en;
  logic       cmd_end;
  logic [1:0] cmd_kind;
  logic       exec_done;
  logic       lowpwr_enter;
  logic       pin_oe, pin_out, ack_done, ack_rd, overrun;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ack_pulse_gen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_en       (ack_en),
    .cmd_end      (cmd_end),
    .cmd_kind     (cmd_kind),
    .exec_done    (exec_done),
    .lowpwr_enter (lowpwr_enter),
    .pin_oe       (pin_oe),
    .pin_out      (pin_out),
    .ack_done     (ack_done),
    .ack_rd       (ack_rd),
    .overrun      (overrun)
  );

  function automatic int exp_lo(input int dly);
    return (dly + 1 > 257) ? dly + 1 : 257;
  endfunction

  function automatic int exp_hi(input int dly);
    return (dly + 8 > 265) ? dly + 8 : 265;
  endfunction

  function automatic bit exp_rd(input logic [1:0] kind);
    return kind == 2'b01;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_oe || ack_done) seen++;
    end
    chk(seen == 0, req, "pin driven or done while quiet", seen, 0);
  endtask

  // One command; offsets k are cycles after the cycle carrying cmd_end.
  task automatic run_cmd(input logic [1:0] kind, input int dly, input int lp_k,
                         input bit lp_in_low, input int ovr_k,
                         input bit drop_in_low, input bit exp_ack);
    int L = -1, phase = 0, lowc = 0, spc = 0, p3 = 0, stray = 0;
    bit fin = 0;
    @(negedge clk);
    cmd_end  = 1'b1;
    cmd_kind = kind;
    for (int k = 1; k <= 1500 && !fin; k++) begin
      @(negedge clk);
      case (phase)
        0: begin
          if (ack_done) stray++;
          if (pin_oe) begin
            if (!pin_out) begin L = k; phase = 1; lowc = 1; end
            else stray++;
          end
        end
        1: begin
          if (pin_oe && !pin_out) lowc++;
          else if (pin_oe) begin phase = 2; spc = 1; end
          else phase = 3;
        end
        2: begin
          if (pin_oe && pin_out) spc++;
          else if (!pin_oe) begin
            chk(ack_done == 1'b1, "R8", "ack_done on release", ack_done, 1);
            chk(ack_rd == exp_rd(kind), "R8", "ack_rd on release", ack_rd, exp_rd(kind));
            phase = 4;
          end else stray++;
        end
        3: begin
          p3++;
          if (pin_oe) stray++;
          if (p3 == 30) ack_en = 1'b1;
        end
        default: begin
          chk(ack_done == 1'b0, "R8", "ack_done one cycle", ack_done, 0);
          fin = 1;
        end
      endcase
      cmd_end = (k == ovr_k);
      if (k == ovr_k) cmd_kind = ~kind;
      exec_done = (k == dly);
      lowpwr_enter = (k == lp_k) || (lp_in_low && phase == 1 && lowc == 40);
      if (drop_in_low && phase == 1 && lowc == 20) ack_en = 1'b0;
    end
    cmd_end = 1'b0; exec_done = 1'b0; lowpwr_enter = 1'b0; ack_en = 1'b1;
    chk(stray == 0, "R3", "unexpected pin or strobe activity", stray, 0);
    if (drop_in_low) begin
      chk(phase == 3 && lowc == 20, "R10", "pulse abandoned when disabled", lowc, 20);
    end else if (exp_ack) begin
      chk(L >= exp_lo(dly), "R4", "low start not before gap", L, exp_lo(dly));
      chk(L <= exp_hi(dly), "R5", "low start after done", L, exp_hi(dly));
      chk(lowc == 128, "R2", "low phase length", lowc, 128);
      chk(spc == 8, "R3", "speedup length", spc, 8);
      chk(phase == 4, "R8", "pulse completed", phase, 4);
    end else begin
      chk(L == -1, "R7", "cancelled command not acknowledged", L, -1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ack_en = 1'b1; cmd_end = 1'b0; cmd_kind = 2'b00;
    exec_done = 1'b0; lowpwr_enter = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(pin_oe == 1'b0, "R1", "pin_oe after reset", pin_oe, 0);
    chk(ack_done == 1'b0, "R1", "ack_done after reset", ack_done, 0);
    chk(ack_rd == 1'b0, "R1", "ack_rd after reset", ack_rd, 0);
    chk(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);

    // R11 done strobe with nothing pending
    exec_done = 1'b1; @(negedge clk); exec_done = 1'b0;
    quiet(400, "R11");

    // R6 early done, read kind; R5 late done, write kind; control kinds
    run_cmd(2'b01, 1, -1, 0, -1, 0, 1);
    run_cmd(2'b00, 600, -1, 0, -1, 0, 1);
    run_cmd(2'b10, 100, -1, 0, -1, 0, 1);
    run_cmd(2'b11, 258, -1, 0, -1, 0, 1);

    // R7 cancel while pending with done latched, then lowpwr during pulse
    run_cmd(2'b01, 5, 100, 0, -1, 0, 0);
    run_cmd(2'b01, 10, -1, 1, -1, 0, 1);

    // R10 disabled: command ignored, no overrun
    ack_en = 1'b0;
    @(negedge clk); cmd_end = 1'b1; cmd_kind = 2'b01;
    @(negedge clk); cmd_end = 1'b0;
    @(negedge clk); exec_done = 1'b1;
    @(negedge clk); exec_done = 1'b0;
    quiet(400, "R10");
    chk(overrun == 1'b0, "R10", "overrun while disabled", overrun, 0);
    ack_en = 1'b1;
    quiet(400, "R10");
    run_cmd(2'b00, 30, -1, 0, -1, 1, 1);

    // R9 second command while pending: ignored, flag set
    chk(overrun == 1'b0, "R9", "overrun before collision", overrun, 0);
    run_cmd(2'b01, 60, -1, 0, 50, 0, 1);
    chk(overrun == 1'b1, "R9", "overrun after collision", overrun, 1);
    run_cmd(2'b00, 20, -1, 0, -1, 0, 1);
    chk(overrun == 1'b1, "R9", "overrun stays set", overrun, 1);

    // Random mix, R4 R5 R7 R8
    for (int i = 0; i < 16; i++) begin
      logic [1:0] kind;
      int dly, lp;
      kind = 2'($urandom_range(0, 3));
      dly  = $urandom_range(1, 500);
      lp   = ($urandom_range(0, 3) == 0) ? $urandom_range(2, 240) : -1;
      run_cmd(kind, dly, lp, 0, -1, 0, lp < 0);
      repeat ($urandom_range(0, 20)) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule